// File: doc/BRIEF.md
# Half-Duplex Command-Buffer SPI Master

This block is a register-driven SPI master that runs one transaction for each start command. A transaction can have up to three phases, always in the same order. First comes a command phase of up to 32 bits, shifted from a right-justified command register. Next comes an outbound data phase of up to 256 bits, taken from an eight-word buffer. Last comes an inbound data phase of up to 256 bits, written back into that same buffer. Software sets the bit count of each phase on every transfer, and a count of zero skips that phase. In normal use a transfer either sends data (command plus outbound data) or receives data (inbound data only).

The serial clock period is the divider field plus two system clocks. A clock-polarity bit, a clock-phase bit and an LSB-first bit set the wire format. The chip selects are active low and stay entirely under software control. The block never releases them between transactions.

The control state machine has five states. `S_IDLE` waits for a start request, and a start request moves it to `S_OPC`. `S_OPC` shifts the command bits and moves to `S_TXD` after its last bit, or at once if its count is zero. `S_TXD` shifts outbound data and moves to `S_RXD` in the same way. `S_RXD` samples inbound data and moves to `S_FIN`. `S_FIN` lasts one cycle and returns to `S_IDLE`. The busy flag is high in every state except `S_IDLE`.

Top module: `spi_hd_master`

## Requirements
- R1: After reset, control reads 0, configuration reads 32'hE000_0004 (transfer-buffer enable bit 2 and select field 31:29 preset), every cs_n pin is high and sclk is low.
- R2: Writing control (address 0) with bit 8 set while idle starts a transfer. Control bit 16 reads 1 from the next cycle until the transfer ends, then reads 0.
- R3: A start write made while bit 16 is 1 is ignored. The running transfer continues and no second transfer follows it.
- R4: The command phase shifts the count register's bits 29:24 worth of bits from the command register (address 1). The command is right-justified there, and the byte sent first sits in the highest occupied byte.
- R5: The outbound data phase sends bits 8:0 of the count register worth of bits from the buffer (addresses 2..9). Byte n of the stream is bits 8(n mod 4)+7:8(n mod 4) of word n/4.
- R6: The inbound phase samples bits 20:12 of the count register worth of bits into the buffer, with the same byte layout. Buffer bytes beyond the count keep their old contents.
- R7: The sclk period is configuration bits 27:16 plus 2 system clocks. Between transfers sclk rests at the polarity bit (configuration bit 4).
- R8: With polarity bit 4 and phase bit 5, data is sampled on rising sclk when the two bits are equal and on falling sclk otherwise. Mosi is stable around each sampling edge.
- R9: Within each byte, bits go out and come in MSB first. When configuration bit 3 is set, they go LSB first.
- R10: Pin cs_n[n] is the inverse of bit n of the chip-select register (address 12). Transfers leave it unchanged.
- R11: A phase whose count is zero produces no sclk edges, and the remaining phases still run in order. A transfer with all counts zero produces no edges and still shows busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address: 0 control, 1 command, 2..9 buffer, 10 configuration, 11 counts, 12 chip select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The assertions assume that software leaves the buffer, configuration and count registers alone while a transfer is busy. They also assume that only one-hot or zero values are written to the chip-select register. The stimulus follows both rules: every register is written only after polling busy low, and chip select is always written as a single shifted bit or zero. Counts stay within 32 command bits and 256 data bits and are whole bytes. The configuration is changed only while every chip select is released, so the bench's serial model never sees polarity changes as clock edges.

// File: rtl/spi_hd_pkg.sv
`timescale 1ns/1ps
package spi_hd_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_OPC  = 3'd1,
        S_TXD  = 3'd2,
        S_RXD  = 3'd3,
        S_FIN  = 3'd4
    } state_t;

    localparam int A_CTRL  = 0;
    localparam int A_OPC   = 1;
    localparam int A_DATA0 = 2;
    localparam int A_CFG   = 10;
    localparam int A_CNT   = 11;
    localparam int A_CS    = 12;

    localparam int START_BIT = 8;
    localparam int BUSY_BIT  = 16;
    localparam int LSB_BIT   = 3;
    localparam int CPOL_BIT  = 4;
    localparam int CPHA_BIT  = 5;
    localparam int DIV_LO    = 16;

    localparam logic [31:0] CFG_RESET = 32'hE000_0004;
    localparam logic [31:0] CNT_MASK  = 32'h3F1F_F1FF;
endpackage

// File: rtl/spi_hd_bitclk.sv
`timescale 1ns/1ps
module spi_hd_bitclk #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic             cpha,
    output logic             bit_end,
    output logic             sample_pt,
    output logic             sclk_act
);
    localparam int CW = DIV_W + 1;

    logic [CW-1:0] cyc_q;
    logic [CW-1:0] period;
    logic [CW-1:0] half;

    assign period = {1'b0, div} + CW'(2);
    assign half   = period >> 1;

    assign bit_end   = run && (cyc_q == period - CW'(1));
    assign sample_pt = run && (cyc_q == half - CW'(1));
    assign sclk_act  = run && (cpha ? (cyc_q < half) : (cyc_q >= half));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (!run || bit_end) begin
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_q + CW'(1);
        end
    end
endmodule

// File: rtl/spi_hd_regs.sv
`timescale 1ns/1ps
module spi_hd_regs #(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       cfg_q,
    output logic [31:0]       cnt_q,
    output logic [31:0]       opc_q,
    output logic [NUM_CS-1:0] cs_q
);
    import spi_hd_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
            cnt_q <= '0;
            opc_q <= '0;
            cs_q  <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(A_CFG)) cfg_q <= reg_wdata;
            if (reg_addr == ADDR_W'(A_CNT)) cnt_q <= reg_wdata & CNT_MASK;
            if (reg_addr == ADDR_W'(A_OPC)) opc_q <= reg_wdata;
            if (reg_addr == ADDR_W'(A_CS))  cs_q  <= reg_wdata[NUM_CS-1:0];
        end
    end
endmodule

// File: rtl/spi_hd_master.sv
`timescale 1ns/1ps
module spi_hd_master #(
    parameter int NUM_CS     = 4,
    parameter int DATA_WORDS = 8,
    parameter int DIV_W      = 12,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);
    import spi_hd_pkg::*;

    localparam int DATA_BITS = 32 * DATA_WORDS;
    localparam int POS_W     = $clog2(DATA_BITS);

    state_t              state_q, state_d;
    logic [5:0]          opc_len_q;
    logic [8:0]          tx_len_q, rx_len_q;
    logic [8:0]          bidx_q;
    logic [DATA_BITS-1:0] buf_q;
    logic [31:0]         cfg_q, cnt_q, opc_q;
    logic [NUM_CS-1:0]   cs_q;
    logic                bit_end, sample_pt, sclk_act;
    logic                run, last_bit, phase_done, start_req, busy;
    logic [8:0]          cur_len;
    logic                lsb, cpol, cpha;
    logic [5:0]          bbyte;
    logic [2:0]          bbit;
    logic [8:0]          opc_pos, dat_pos9;
    logic [POS_W-1:0]    dat_pos;

    assign lsb  = cfg_q[LSB_BIT];
    assign cpol = cfg_q[CPOL_BIT];
    assign cpha = cfg_q[CPHA_BIT];
    assign busy = (state_q != S_IDLE);

    spi_hd_regs #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cfg_q(cfg_q), .cnt_q(cnt_q),
        .opc_q(opc_q), .cs_q(cs_q)
    );

    spi_hd_bitclk #(.DIV_W(DIV_W)) u_bitclk (
        .clk(clk), .rst_n(rst_n), .run(run),
        .div(cfg_q[DIV_LO +: DIV_W]), .cpha(cpha),
        .bit_end(bit_end), .sample_pt(sample_pt), .sclk_act(sclk_act)
    );

    assign start_req = reg_wr && (reg_addr == ADDR_W'(A_CTRL))
                       && reg_wdata[START_BIT] && !busy;

    // length of the phase currently being shifted
    always_comb begin
        unique case (state_q)
            S_OPC:   cur_len = {3'b000, opc_len_q};
            S_TXD:   cur_len = tx_len_q;
            S_RXD:   cur_len = rx_len_q;
            default: cur_len = '0;
        endcase
    end

    assign run        = (cur_len != 9'd0);
    assign last_bit   = (bidx_q == cur_len - 9'd1);
    assign phase_done = !run || (bit_end && last_bit);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_req)  state_d = S_OPC;
            S_OPC:   if (phase_done) state_d = S_TXD;
            S_TXD:   if (phase_done) state_d = S_RXD;
            S_RXD:   if (phase_done) state_d = S_FIN;
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register, latched counts and bit index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            opc_len_q <= '0;
            tx_len_q  <= '0;
            rx_len_q  <= '0;
            bidx_q    <= '0;
        end else begin
            state_q <= state_d;
            if (start_req) begin
                opc_len_q <= cnt_q[29:24];
                rx_len_q  <= cnt_q[20:12];
                tx_len_q  <= cnt_q[8:0];
            end
            if (state_q != state_d) begin
                bidx_q <= '0;
            end else if (bit_end) begin
                bidx_q <= bidx_q + 9'd1;
            end
        end
    end

    // bit position of the current serial bit
    assign bbyte    = bidx_q[8:3];
    assign bbit     = bidx_q[2:0];
    assign opc_pos  = lsb ? ({3'b000, opc_len_q} - ({bbyte, 3'b000} + 9'd8) + {6'd0, bbit})
                          : ({3'b000, opc_len_q} - 9'd1 - bidx_q);
    assign dat_pos9 = {bbyte, 3'b000} + {6'd0, (lsb ? bbit : (3'd7 - bbit))};
    assign dat_pos  = POS_W'(dat_pos9);

    // data buffer: register writes, then serial capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            for (int w = 0; w < DATA_WORDS; w++) begin
                if (reg_wr && reg_addr == ADDR_W'(A_DATA0 + w)) begin
                    buf_q[32*w +: 32] <= reg_wdata;
                end
            end
            if (state_q == S_RXD && sample_pt) begin
                buf_q[dat_pos] <= miso;
            end
        end
    end

    // serial outputs
    always_comb begin
        sclk = cpol ^ sclk_act;
        mosi = 1'b0;
        unique case (state_q)
            S_OPC:   if (run) mosi = opc_q[opc_pos[4:0]];
            S_TXD:   if (run) mosi = buf_q[dat_pos];
            default: mosi = 1'b0;
        endcase
        cs_n = ~cs_q;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_CTRL)) reg_rdata[BUSY_BIT] = busy;
        if (reg_addr == ADDR_W'(A_OPC))  reg_rdata = opc_q;
        if (reg_addr == ADDR_W'(A_CFG))  reg_rdata = cfg_q;
        if (reg_addr == ADDR_W'(A_CNT))  reg_rdata = cnt_q;
        if (reg_addr == ADDR_W'(A_CS))   reg_rdata = 32'(cs_q);
        for (int w = 0; w < DATA_WORDS; w++) begin
            if (reg_addr == ADDR_W'(A_DATA0 + w)) reg_rdata = buf_q[32*w +: 32];
        end
    end
endmodule

// File: rtl/spi_hd_master_chk.sv
`timescale 1ns/1ps
module spi_hd_master_chk #(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [31:0]         reg_wdata,
    input spi_hd_pkg::state_t  state,
    input logic                bit_end,
    input logic [5:0]          opc_len,
    input logic                cpol,
    input logic                sclk,
    input logic                mosi,
    input logic [NUM_CS-1:0]   cs_n
);
    import spi_hd_pkg::*;

    logic busy;
    logic start_wr;
    assign busy     = (state != S_IDLE);
    assign start_wr = reg_wr && (reg_addr == ADDR_W'(A_CTRL)) && reg_wdata[START_BIT];

    // R2: busy only rises after a start write
    a_r2_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_wr));

    // R3: a start while busy never restarts the command phase
    a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_wr) |=> !(state == S_OPC && $past(state) != S_OPC));

    // R7: idle clock level follows polarity
    a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (sclk == cpol));

    // R8: mosi only moves at bit boundaries during outbound data
    a_r8_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TXD && $past(state) == S_TXD && !$past(bit_end) && !$past(reg_wr))
        |-> $stable(mosi));

    // R10: chip selects change only through their register
    a_r10_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_W'(A_CS)) |=> $stable(cs_n));

    a_r10_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R11: an empty command phase passes straight on
    a_r11_zero_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OPC && opc_len == 6'd0) |=> (state == S_TXD));
endmodule

bind spi_hd_master spi_hd_master_chk #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .state(state_q), .bit_end(bit_end),
    .opc_len(opc_len_q), .cpol(cfg_q[4]), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
);

// File: tb/spi_hd_master_tb_top.sv
`timescale 1ns/1ps
module spi_hd_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi, miso;
    logic [3:0]  cs_n;

    always #4 clk = ~clk;

    spi_hd_master dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int   n_chk = 0;
    int   n_bad = 0;
    bit   cpol_t = 0, cpha_t = 0, lsb_t = 0;
    int   div_t = 0;
    int   mcnt = 0;
    int   rx_base = 0;
    logic mlog [0:1023];
    logic [7:0] srx [0:31];
    logic [7:0] opb [0:3];
    logic [7:0] txb [0:31];
    logic [31:0] fillw [0:7];
    time  t_prev = 0, t_last = 0;

    // serial peer: logs mosi and advances miso on each sampling edge
    always @(sclk) begin
        if (cs_n != 4'hF && sclk == ~(cpol_t ^ cpha_t)) begin
            mlog[mcnt % 1024] = mosi;
            mcnt   = mcnt + 1;
            t_prev = t_last;
            t_last = $time;
        end
    end

    always_comb begin
        int s;
        s = mcnt - rx_base;
        if (s < 0 || s >= 256) miso = 1'b0;
        else miso = srx[s / 8][lsb_t ? (s % 8) : (7 - s % 8)];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 4'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 30000; i++) begin
            rd(0, d);
            if (!d[16]) return;
            @(negedge clk);
        end
    endtask

    task automatic set_cfg(input int dv, input bit pol, input bit pha, input bit lf);
        wr(12, 32'h0);
        wr(10, 32'hE000_0004 | (32'(dv) << 16) | (32'(pha) << 5) | (32'(pol) << 4) | (32'(lf) << 3));
        div_t = dv; cpol_t = pol; cpha_t = pha; lsb_t = lf;
    endtask

    function automatic logic exp_bit(input int k, input int nopc);
        int j;
        if (k < 8 * nopc) begin
            j = k;
            return opb[j / 8][lsb_t ? (j % 8) : (7 - j % 8)];
        end
        j = k - 8 * nopc;
        return txb[j / 8][lsb_t ? (j % 8) : (7 - j % 8)];
    endfunction

    task automatic run_xfer(input int nopc, input int ntx, input int nrx,
                            input int sel, input bit dbl, input string req);
        logic [31:0] d, ov, ew;
        int base, errs, first_bad, tot;
        ov = 0;
        for (int i = 0; i < nopc; i++) ov = (ov << 8) | 32'(opb[i]);
        wr(1, ov);
        for (int w = 0; w < 8; w++) begin
            if (nrx > 0) begin
                fillw[w] = $urandom;
                wr(2 + w, fillw[w]);
            end else begin
                wr(2 + w, {txb[4*w+3], txb[4*w+2], txb[4*w+1], txb[4*w]});
            end
        end
        wr(11, (32'(8 * nopc) << 24) | (32'(8 * nrx) << 12) | 32'(8 * ntx));
        wr(12, 32'(1) << sel);
        base = mcnt; rx_base = mcnt;
        tot = 8 * (nopc + ntx + nrx);
        wr(0, 32'h100);
        rd(0, d);
        check(d[16] == 1'b1, "R2", "busy after start", d[16], 1);
        if (dbl) begin
            repeat (6) @(negedge clk);
            wr(0, 32'h100);  // R3: ignored second start
        end
        wait_idle();
        repeat (3) @(negedge clk);
        rd(0, d);
        check(d[16] == 1'b0, "R2", "busy cleared", d[16], 0);
        check(mcnt - base == tot, dbl ? "R3" : "R11", "sampling edge count", mcnt - base, tot);
        errs = 0; first_bad = -1;
        for (int k = 0; k < 8 * (nopc + ntx); k++) begin
            if (mlog[(base + k) % 1024] !== exp_bit(k, nopc)) begin
                errs++;
                if (first_bad < 0) first_bad = k;
            end
        end
        if (nopc + ntx > 0)
            check(errs == 0, req, "mosi stream mismatches (first bad bit index in actual)", first_bad, -1);
        if (nrx > 0) begin
            for (int w = 0; w < 8; w++) begin
                rd(2 + w, d);
                for (int b = 0; b < 4; b++)
                    ew[8*b +: 8] = (4*w + b < nrx) ? srx[4*w + b] : fillw[w][8*b +: 8];
                check(d == ew, req, $sformatf("buffer word %0d", w), d, ew);
            end
        end
        if (tot >= 2)
            check(t_last - t_prev == time'((div_t + 2) * 8), "R7", "sclk period ns",
                  t_last - t_prev, (div_t + 2) * 8);
        check(sclk == cpol_t, "R7", "idle sclk level", sclk, cpol_t);
        check(cs_n == ~(4'(1) << sel), "R10", "cs held after transfer", cs_n, ~(4'(1) << sel));
        wr(12, 32'h0);
        check(cs_n == 4'hF, "R10", "cs released", cs_n, 4'hF);
    endtask

    task automatic fill_bytes();
        for (int i = 0; i < 4; i++)  opb[i] = 8'($urandom);
        for (int i = 0; i < 32; i++) begin
            txb[i] = 8'($urandom);
            srx[i] = 8'($urandom);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) mlog[i] = 1'b0;
        fill_bytes();
        for (int w = 0; w < 8; w++) fillw[w] = '0;
        repeat (3) @(negedge clk);
        rd(0, d);  check(d == 32'h0, "R1", "control after reset", d, 0);
        rd(10, d); check(d == 32'hE000_0004, "R1", "config after reset", d, 32'hE000_0004);
        check(cs_n == 4'hF, "R1", "cs_n after reset (before release)", cs_n, 4'hF);
        rst_n = 1'b1;
        @(negedge clk);
        check(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);
        wr(12, 32'h4);
        check(cs_n == 4'b1011, "R10", "cs_n one-hot inverse", cs_n, 4'b1011);

        // directed corners
        set_cfg(0, 0, 0, 0); fill_bytes(); opb[0] = 8'h9F;
        run_xfer(1, 3, 0, 2, 0, "R4");
        set_cfg(5, 1, 1, 1); fill_bytes();
        run_xfer(4, 32, 0, 1, 1, "R9");
        set_cfg(2, 0, 1, 0); fill_bytes();
        run_xfer(0, 0, 32, 0, 0, "R6");
        set_cfg(1, 1, 0, 1); fill_bytes();
        run_xfer(0, 0, 5, 3, 0, "R6");
        set_cfg(0, 0, 0, 0);
        run_xfer(0, 0, 0, 0, 0, "R11");
        fill_bytes();
        run_xfer(0, 2, 0, 1, 0, "R5");

        // constrained random mix
        for (int it = 0; it < 14; it++) begin
            int no, nt, nr;
            set_cfg(int'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom));
            fill_bytes();
            if ($urandom % 2 == 0) begin
                no = int'($urandom % 5); nt = int'($urandom % 33); nr = 0;
            end else begin
                no = 0; nt = 0; nr = 1 + int'($urandom % 32);
            end
            run_xfer(no, nt, nr, int'($urandom % 4), 0, "R8");
        end
        summary();
    end
endmodule